// File: doc/BRIEF.md
# Rectangle Copy and Fill Engine

A small 2D drawing engine that sits next to its own byte-wide frame memory. Software sets up a rectangle through 32-bit registers: the origin of a source and a destination, a width and a height, two base addresses in 8-byte units, two line pitches in 8-byte units, a foreground colour and a pixel depth of 8, 16 or 32 bits. A write to the command register then either copies the source rectangle onto the destination or paints the destination with one of four raster operations.

The engine handles one pixel per clock. In each cycle it reads the source and destination pixels and writes the result back, so a copy between overlapping areas gives the right result when software picks the walk direction on each axis. A copy that moves data right or down must walk right-to-left or bottom-to-top, with the programmed coordinates marking the far edge. The status register reports busy until the rectangle is finished. A command that cannot be run, or that arrives while busy, only sets a sticky error flag. A byte-wide test port reads and loads the frame memory directly.

Top module: `rect_blit_engine`

## Requirements
- R1: Register word addresses: 0 command, 1 source XY, 2 destination XY, 3 size, 4 source base, 5 destination base, 6 pitch, 7 foreground, 8 mode, 9 status, 10 depth-only. The XY registers hold X in bits 11:0 and Y in bits 27:16. The size register holds width-1 in bits 11:0 and height-1 in bits 27:16. Bits outside these fields are not stored and read back as zero.
- R2: The byte address of pixel (x,y) is base*8 + y*pitch*8 + x*B, where B is the number of bytes per pixel. The pitch register holds the source pitch/8 in bits 10:0 and the destination pitch/8 in bits 26:16. A multi-byte pixel is stored least significant byte first.
- R3: Mode bits 1:0 select the depth: 0 gives 8 bits, 1 gives 16 bits, 2 or 3 give 32 bits. The mode register stores all 32 bits. A write to the depth-only register changes mode bits 1:0 and leaves the other 30 bits unchanged.
- R4: Command bit 13 set selects a fill with the raster operation in bits 31:24. 0x00 writes all zeros, 0xFF writes all ones, 0xF0 writes the foreground colour, and 0x5A writes the foreground XOR the old destination pixel.
- R5: Command bit 13 clear with raster operation 0xCC copies the source pixels to the destination unchanged.
- R6: Command bit 15 walks X from right to left, with both programmed X coordinates marking the rightmost column. A one-pixel shift to the right over an overlapping row then keeps every source value.
- R7: Command bit 14 walks Y from bottom to top, with both programmed Y coordinates marking the bottom row. An overlapping one-row downward shift then keeps every source value.
- R8: An accepted command writes one pixel per clock. Status bit 0 reads 1 for exactly width*height+1 cycles, from the edge that takes the command until one cycle after the last pixel write. No memory write happens outside that window.
- R9: While busy, a command write is ignored and sets sticky status bit 1. Writes to the configuration registers (addresses 1 to 8 and 10) are ignored while busy.
- R10: A fill with an operation other than the four in R4, or a copy with an operation other than 0xCC, does not start. It writes no memory and sets sticky status bit 2.
- R11: A status write clears bit 1 and bit 2 wherever the written data has a 1.
- R12: The test port reads any frame-memory byte combinationally and writes a byte on the clock edge when the engine is not writing.
- R13: After reset, every register, including status, reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| tp_we | input | 1 | Test-port byte write strobe |
| tp_addr | input | MEM_AW | Test-port byte address |
| tp_wdata | input | 8 | Test-port write byte |
| tp_rdata | output | 8 | Test-port read byte (combinational) |

## Verification
A wrong pixel counter shows in the first command as a busy window that differs from width*height+1 cycles, and as bytes painted outside the rectangle or missing inside it. A wrong walk direction does not change the busy time, but an overlapping copy fills the row or column with copies of a single value, which the test port shows right after the command finishes. Bad sticky-flag or ignore handling shows on the next status or register read-back, after the busy window of the command it belongs to.

// File: rtl/blit_pkg.sv
package blit_pkg;

   localparam logic [3:0] RA_CMD   = 4'd0;
   localparam logic [3:0] RA_SXY   = 4'd1;
   localparam logic [3:0] RA_DXY   = 4'd2;
   localparam logic [3:0] RA_SIZE  = 4'd3;
   localparam logic [3:0] RA_SBASE = 4'd4;
   localparam logic [3:0] RA_DBASE = 4'd5;
   localparam logic [3:0] RA_PITCH = 4'd6;
   localparam logic [3:0] RA_FG    = 4'd7;
   localparam logic [3:0] RA_MODE  = 4'd8;
   localparam logic [3:0] RA_STAT  = 4'd9;
   localparam logic [3:0] RA_DEPTH = 4'd10;

   localparam logic [7:0] ROP_ZERO    = 8'h00;
   localparam logic [7:0] ROP_PAT_XOR = 8'h5A;
   localparam logic [7:0] ROP_PAT     = 8'hF0;
   localparam logic [7:0] ROP_ONE     = 8'hFF;
   localparam logic [7:0] ROP_SRC     = 8'hCC;

   localparam int CMD_XNEG = 15;
   localparam int CMD_YNEG = 14;
   localparam int CMD_FILL = 13;

   typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} walk_state_t;

   function automatic logic cmd_legal(input logic [31:0] c);
      logic [7:0] op;
      op = c[31:24];
      if (c[CMD_FILL])
         return (op == ROP_ZERO) || (op == ROP_PAT_XOR) || (op == ROP_PAT) || (op == ROP_ONE);
      return op == ROP_SRC;
   endfunction

   function automatic logic [2:0] depth_bytes(input logic [1:0] code);
      case (code)
         2'd0:    return 3'd1;
         2'd1:    return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/blit_regs.sv
module blit_regs
   import blit_pkg::*;
#(
   parameter int COORD_W = 12,
   parameter int PITCH_W = 11,
   parameter int BASE_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [3:0]         reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic               busy,
   output logic               start,
   output logic [31:0]        cmd_q,
   output logic [COORD_W-1:0] sx, sy, dx, dy, wm1, hm1,
   output logic [BASE_W-1:0]  sbase, dbase,
   output logic [PITCH_W-1:0] spitch, dpitch,
   output logic [31:0]        fg,
   output logic [2:0]         bpb,
   output logic               err_busy,
   output logic               err_rop
);

   logic [31:0] mode_q;
   logic        cmd_wr;

   assign cmd_wr = reg_we && (reg_addr == RA_CMD);
   assign start  = cmd_wr && !busy && cmd_legal(reg_wdata);
   assign bpb    = depth_bytes(mode_q[1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;  mode_q <= '0;  fg <= '0;
         sx <= '0;  sy <= '0;  dx <= '0;  dy <= '0;  wm1 <= '0;  hm1 <= '0;
         sbase <= '0;  dbase <= '0;  spitch <= '0;  dpitch <= '0;
         err_busy <= 1'b0;  err_rop <= 1'b0;
      end else if (reg_we) begin
         if (reg_addr == RA_STAT) begin
            if (reg_wdata[1]) err_busy <= 1'b0;
            if (reg_wdata[2]) err_rop  <= 1'b0;
         end else if (busy) begin
            if (cmd_wr) err_busy <= 1'b1;
         end else begin
            case (reg_addr)
               RA_CMD: begin
                  if (cmd_legal(reg_wdata)) cmd_q <= reg_wdata;
                  else                      err_rop <= 1'b1;
               end
               RA_SXY:   begin sx  <= reg_wdata[COORD_W-1:0]; sy  <= reg_wdata[16 +: COORD_W]; end
               RA_DXY:   begin dx  <= reg_wdata[COORD_W-1:0]; dy  <= reg_wdata[16 +: COORD_W]; end
               RA_SIZE:  begin wm1 <= reg_wdata[COORD_W-1:0]; hm1 <= reg_wdata[16 +: COORD_W]; end
               RA_SBASE: sbase <= reg_wdata[BASE_W-1:0];
               RA_DBASE: dbase <= reg_wdata[BASE_W-1:0];
               RA_PITCH: begin spitch <= reg_wdata[PITCH_W-1:0]; dpitch <= reg_wdata[16 +: PITCH_W]; end
               RA_FG:    fg <= reg_wdata;
               RA_MODE:  mode_q <= reg_wdata;
               RA_DEPTH: mode_q[1:0] <= reg_wdata[1:0];
               default:  ;
            endcase
         end
      end
   end

   always_comb begin
      case (reg_addr)
         RA_CMD:   reg_rdata = cmd_q;
         RA_SXY:   reg_rdata = (32'(sy) << 16) | 32'(sx);
         RA_DXY:   reg_rdata = (32'(dy) << 16) | 32'(dx);
         RA_SIZE:  reg_rdata = (32'(hm1) << 16) | 32'(wm1);
         RA_SBASE: reg_rdata = 32'(sbase);
         RA_DBASE: reg_rdata = 32'(dbase);
         RA_PITCH: reg_rdata = (32'(dpitch) << 16) | 32'(spitch);
         RA_FG:    reg_rdata = fg;
         RA_MODE:  reg_rdata = mode_q;
         RA_STAT:  reg_rdata = {29'd0, err_rop, err_busy, busy};
         default:  reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/blit_walker.sv
module blit_walker
   import blit_pkg::*;
#(
   parameter int COORD_W = 12,
   parameter int PITCH_W = 11,
   parameter int BASE_W  = 16,
   parameter int MEM_AW  = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               xneg,
   input  logic               yneg,
   input  logic [COORD_W-1:0] sx, sy, dx, dy, wm1, hm1,
   input  logic [BASE_W-1:0]  sbase, dbase,
   input  logic [PITCH_W-1:0] spitch, dpitch,
   input  logic [2:0]         bpb,
   output logic               busy,
   output logic               pix_we,
   output logic [MEM_AW-1:0]  src_addr,
   output logic [MEM_AW-1:0]  dst_addr
);

   walk_state_t        state_q;
   logic [COORD_W-1:0] cx_q, cy_q;

   function automatic logic [31:0] step(input logic [31:0] org, input logic [31:0] ofs,
                                        input logic neg);
      return neg ? (org - ofs) : (org + ofs);
   endfunction

   function automatic logic [31:0] byte_addr(input logic [31:0] base8, input logic [31:0] pitch8,
                                             input logic [31:0] x, input logic [31:0] y,
                                             input logic [31:0] nbytes);
      return (base8 << 3) + y * (pitch8 << 3) + x * nbytes;
   endfunction

   always_comb begin
      logic [31:0] sxa, sya, dxa, dya;
      sxa = step(32'(sx), 32'(cx_q), xneg);
      dxa = step(32'(dx), 32'(cx_q), xneg);
      sya = step(32'(sy), 32'(cy_q), yneg);
      dya = step(32'(dy), 32'(cy_q), yneg);
      src_addr = MEM_AW'(byte_addr(32'(sbase), 32'(spitch), sxa, sya, 32'(bpb)));
      dst_addr = MEM_AW'(byte_addr(32'(dbase), 32'(dpitch), dxa, dya, 32'(bpb)));
   end

   assign busy   = (state_q != ST_IDLE);
   assign pix_we = (state_q == ST_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cx_q    <= '0;
         cy_q    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (start) begin
               state_q <= ST_RUN;
               cx_q    <= '0;
               cy_q    <= '0;
            end
            ST_RUN: begin
               if (cx_q == wm1) begin
                  cx_q <= '0;
                  if (cy_q == hm1) state_q <= ST_DONE;
                  else             cy_q <= cy_q + 1'b1;
               end else begin
                  cx_q <= cx_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/blit_pixel_alu.sv
module blit_pixel_alu
   import blit_pkg::*;
(
   input  logic        fill,
   input  logic [7:0]  rop,
   input  logic [31:0] src_pix,
   input  logic [31:0] dst_pix,
   input  logic [31:0] fg,
   output logic [31:0] out_pix
);

   always_comb begin
      if (!fill) begin
         out_pix = src_pix;
      end else begin
         case (rop)
            ROP_ONE:     out_pix = '1;
            ROP_PAT:     out_pix = fg;
            ROP_PAT_XOR: out_pix = fg ^ dst_pix;
            default:     out_pix = '0;
         endcase
      end
   end

endmodule

// File: rtl/blit_frame_ram.sv
module blit_frame_ram #(
   parameter int MEM_BYTES = 4096,
   parameter int LANES     = 4,
   localparam int MEM_AW   = $clog2(MEM_BYTES)
) (
   input  logic                 clk,
   input  logic                 eng_we,
   input  logic [2:0]           bpb,
   input  logic [MEM_AW-1:0]    a_addr,
   output logic [8*LANES-1:0]   a_data,
   input  logic [MEM_AW-1:0]    b_addr,
   output logic [8*LANES-1:0]   b_data,
   input  logic [8*LANES-1:0]   b_wdata,
   input  logic                 tp_we,
   input  logic [MEM_AW-1:0]    tp_addr,
   input  logic [7:0]           tp_wdata,
   output logic [7:0]           tp_rdata
);

   logic [7:0] mem [MEM_BYTES];

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign a_data[8*i +: 8] = mem[a_addr + MEM_AW'(i)];
      assign b_data[8*i +: 8] = mem[b_addr + MEM_AW'(i)];
   end

   assign tp_rdata = mem[tp_addr];

   always_ff @(posedge clk) begin
      if (eng_we) begin
         for (int i = 0; i < LANES; i++)
            if (3'(i) < bpb) mem[b_addr + MEM_AW'(i)] <= b_wdata[8*i +: 8];
      end else if (tp_we) begin
         mem[tp_addr] <= tp_wdata;
      end
   end

endmodule

// File: rtl/rect_blit_engine.sv
module rect_blit_engine
   import blit_pkg::*;
#(
   parameter int  COORD_W   = 12,
   parameter int  PITCH_W   = 11,
   parameter int  BASE_W    = 16,
   parameter int  MEM_BYTES = 4096,
   localparam int MEM_AW    = $clog2(MEM_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [3:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              tp_we,
   input  logic [MEM_AW-1:0] tp_addr,
   input  logic [7:0]        tp_wdata,
   output logic [7:0]        tp_rdata
);

   initial begin
      assert (COORD_W >= 2 && COORD_W <= 12) else $fatal(1, "COORD_W out of range");
      assert (PITCH_W >= 1 && PITCH_W <= 11) else $fatal(1, "PITCH_W out of range");
      assert (BASE_W >= 1 && BASE_W <= 29)   else $fatal(1, "BASE_W out of range");
      assert (MEM_BYTES >= 64 && (MEM_BYTES & (MEM_BYTES - 1)) == 0)
         else $fatal(1, "MEM_BYTES must be a power of two of at least 64");
   end

   logic               busy, start, pix_we, err_busy, err_rop;
   logic [31:0]        cmd_q, fg, src_pix, dst_pix, out_pix;
   logic [COORD_W-1:0] sx, sy, dx, dy, wm1, hm1;
   logic [BASE_W-1:0]  sbase, dbase;
   logic [PITCH_W-1:0] spitch, dpitch;
   logic [2:0]         bpb;
   logic [MEM_AW-1:0]  src_addr, dst_addr;

   blit_regs #(.COORD_W(COORD_W), .PITCH_W(PITCH_W), .BASE_W(BASE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .start(start),
      .cmd_q(cmd_q), .sx(sx), .sy(sy), .dx(dx), .dy(dy), .wm1(wm1), .hm1(hm1),
      .sbase(sbase), .dbase(dbase), .spitch(spitch), .dpitch(dpitch), .fg(fg),
      .bpb(bpb), .err_busy(err_busy), .err_rop(err_rop)
   );

   blit_walker #(.COORD_W(COORD_W), .PITCH_W(PITCH_W), .BASE_W(BASE_W), .MEM_AW(MEM_AW)) u_walk (
      .clk(clk), .rst_n(rst_n), .start(start),
      .xneg(cmd_q[CMD_XNEG]), .yneg(cmd_q[CMD_YNEG]),
      .sx(sx), .sy(sy), .dx(dx), .dy(dy), .wm1(wm1), .hm1(hm1),
      .sbase(sbase), .dbase(dbase), .spitch(spitch), .dpitch(dpitch), .bpb(bpb),
      .busy(busy), .pix_we(pix_we), .src_addr(src_addr), .dst_addr(dst_addr)
   );

   blit_pixel_alu u_alu (
      .fill(cmd_q[CMD_FILL]), .rop(cmd_q[31:24]), .src_pix(src_pix),
      .dst_pix(dst_pix), .fg(fg), .out_pix(out_pix)
   );

   blit_frame_ram #(.MEM_BYTES(MEM_BYTES), .LANES(4)) u_ram (
      .clk(clk), .eng_we(pix_we), .bpb(bpb),
      .a_addr(src_addr), .a_data(src_pix),
      .b_addr(dst_addr), .b_data(dst_pix), .b_wdata(out_pix),
      .tp_we(tp_we), .tp_addr(tp_addr), .tp_wdata(tp_wdata), .tp_rdata(tp_rdata)
   );

endmodule

// File: rtl/blit_checker.sv
module blit_checker
   import blit_pkg::*;
#(
   parameter int COORD_W = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               busy,
   input logic               pix_we,
   input logic               reg_we,
   input logic [3:0]         reg_addr,
   input logic [31:0]        reg_wdata,
   input logic               err_busy,
   input logic               err_rop,
   input logic [COORD_W-1:0] wm1,
   input logic [COORD_W-1:0] hm1
);

   AST_WRITE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      pix_we |-> busy);  // R8

   AST_TAIL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !pix_we) |=> !busy);  // R8

   AST_BUSY_CMD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == RA_CMD && busy) |=> err_busy);  // R9

   AST_SIZE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(wm1) && $stable(hm1)));  // R9

   AST_BAD_OP_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == RA_CMD && !busy && !cmd_legal(reg_wdata)) |=> (!busy && err_rop));  // R10

endmodule

bind rect_blit_engine blit_checker #(.COORD_W(COORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .pix_we(pix_we), .reg_we(reg_we),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .err_busy(err_busy),
   .err_rop(err_rop), .wm1(wm1), .hm1(hm1)
);

// File: tb/rect_blit_engine_test.sv
module rect_blit_engine_test;

   localparam logic [3:0] A_CMD = 4'd0, A_SXY = 4'd1, A_DXY = 4'd2, A_SIZE = 4'd3;
   localparam logic [3:0] A_SB = 4'd4, A_DB = 4'd5, A_PITCH = 4'd6, A_FG = 4'd7;
   localparam logic [3:0] A_MODE = 4'd8, A_STAT = 4'd9, A_DEPTH = 4'd10;
   localparam logic [31:0] FILL = 32'h0000_2000, XNEG = 32'h0000_8000, YNEG = 32'h0000_4000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        tp_we = 1'b0;
   logic [11:0] tp_addr = '0;
   logic [7:0]  tp_wdata = '0;
   logic [7:0]  tp_rdata;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  finished = 1'b0;

   always #4 clk = ~clk;

   rect_blit_engine uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tp_we(tp_we),
      .tp_addr(tp_addr), .tp_wdata(tp_wdata), .tp_rdata(tp_rdata)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk); reg_addr = a; #1 d = reg_rdata;
   endtask

   task automatic mem_wr(input int a, input logic [7:0] d);
      @(negedge clk); tp_we = 1'b1; tp_addr = 12'(a); tp_wdata = d;
      @(negedge clk); tp_we = 1'b0;
   endtask

   task automatic mem_chk(input string tag, input int a, input logic [7:0] exp);
      @(negedge clk); tp_addr = 12'(a); #1;
      chk(tag, 32'(tp_rdata), 32'(exp));
   endtask

   // start a command and count the cycles in which status bit 0 reads 1
   task automatic run(input logic [31:0] cmd, output int cyc);
      wr(A_CMD, cmd);
      cyc = 0;
      reg_addr = A_STAT; #1;
      while (reg_rdata[0] && cyc < 100000) begin
         cyc++;
         @(negedge clk); reg_addr = A_STAT; #1;
      end
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(A_STAT, d);  chk("R13 status", d, 32'h0);
      rd(A_MODE, d);  chk("R13 mode", d, 32'h0);
      rd(A_DXY, d);   chk("R13 dst xy", d, 32'h0);
      rd(A_CMD, d);   chk("R13 cmd", d, 32'h0);
   endtask

   task automatic t_fields;
      logic [31:0] d;
      wr(A_SXY, 32'hFFFF_FFFF);   rd(A_SXY, d);   chk("R1 xy mask", d, 32'h0FFF_0FFF);
      wr(A_SIZE, 32'hFFFF_FFFF);  rd(A_SIZE, d);  chk("R1 size mask", d, 32'h0FFF_0FFF);
      wr(A_PITCH, 32'hFFFF_FFFF); rd(A_PITCH, d); chk("R2 pitch mask", d, 32'h07FF_07FF);
      wr(A_MODE, 32'hABCD_0001);  wr(A_DEPTH, 32'hFFFF_FFFE);
      rd(A_MODE, d);              chk("R3 depth keeps upper mode bits", d, 32'hABCD_0002);
      wr(A_MODE, 32'h0);
   endtask

   task automatic t_testport;
      for (int a = 0; a < 1024; a++) mem_wr(a, 8'h00);
      mem_wr(1000, 8'h9E);
      mem_chk("R12 test port byte", 1000, 8'h9E);
      mem_chk("R12 test port neighbour", 1001, 8'h00);
   endtask

   task automatic t_fill8;
      int cyc;
      wr(A_DEPTH, 0); wr(A_DB, 2); wr(A_PITCH, 32'h0004_0004);
      wr(A_DXY, 32'h0001_0002); wr(A_SIZE, 32'h0001_0002); wr(A_FG, 32'h0000_00A5);
      run(32'hF000_0000 | FILL, cyc);
      chk("R8 busy cycles 3x2 fill", 32'(cyc), 32'd7);
      for (int y = 1; y <= 2; y++)
         for (int x = 1; x <= 5; x++)
            mem_chk("R4 R2 fill8 pattern", 16 + y*32 + x, (x >= 2 && x <= 4) ? 8'hA5 : 8'h00);
   endtask

   task automatic t_fill16_xor;
      int cyc;
      mem_wr(176, 8'h11); mem_wr(177, 8'h22); mem_wr(178, 8'h33); mem_wr(179, 8'h44);
      wr(A_DEPTH, 1); wr(A_DXY, 32'h0005_0000); wr(A_SIZE, 32'h0000_0001); wr(A_FG, 32'h0000_FFF0);
      run(32'h5A00_0000 | FILL, cyc);
      mem_chk("R4 xor16 b0", 176, 8'hE1); mem_chk("R4 xor16 b1", 177, 8'hDD);
      mem_chk("R4 xor16 b2", 178, 8'hC3); mem_chk("R4 xor16 b3", 179, 8'hBB);
      mem_chk("R2 16bpp stops at pixel end", 180, 8'h00);
   endtask

   task automatic t_fill32;
      int cyc;
      mem_wr(239, 8'h77);
      wr(A_DEPTH, 2); wr(A_DXY, 32'h0007_0000); wr(A_SIZE, 32'h0);
      run(32'hFF00_0000 | FILL, cyc);
      for (int i = 0; i < 4; i++) mem_chk("R4 ones32", 240 + i, 8'hFF);
      mem_chk("R3 32bpp lower edge", 239, 8'h77);
      mem_chk("R3 32bpp upper edge", 244, 8'h00);
      run(32'h0000_0000 | FILL, cyc);
      mem_chk("R4 zeros32", 241, 8'h00);
   endtask

   task automatic t_copy;
      int cyc;
      for (int i = 0; i < 4; i++) mem_wr(320 + i, 8'(i + 1));
      wr(A_DEPTH, 0); wr(A_SB, 0); wr(A_DB, 0);
      wr(A_SXY, 32'h000A_0000); wr(A_DXY, 32'h000C_0008); wr(A_SIZE, 32'h0000_0003);
      run(32'hCC00_0000, cyc);
      chk("R8 busy cycles 4x1 copy", 32'(cyc), 32'd5);
      for (int i = 0; i < 4; i++) mem_chk("R5 copy byte", 392 + i, 8'(i + 1));
   endtask

   task automatic t_overlap_x;
      int cyc;
      for (int i = 0; i < 8; i++) mem_wr(448 + i, 8'(8'h10 + i));
      wr(A_SXY, 32'h000E_0006); wr(A_DXY, 32'h000E_0007); wr(A_SIZE, 32'h0000_0006);
      run(32'hCC00_0000 | XNEG, cyc);
      mem_chk("R6 leftmost kept", 448, 8'h10);
      for (int i = 1; i < 8; i++) mem_chk("R6 right shift", 448 + i, 8'(8'h10 + i - 1));
   endtask

   task automatic t_overlap_y;
      int cyc;
      for (int y = 0; y < 4; y++) mem_wr(y*32 + 24, 8'(8'h50 + y));
      wr(A_SXY, 32'h0002_0018); wr(A_DXY, 32'h0003_0018); wr(A_SIZE, 32'h0002_0000);
      run(32'hCC00_0000 | YNEG, cyc);
      mem_chk("R7 top kept", 24, 8'h50);
      for (int y = 1; y < 4; y++) mem_chk("R7 down shift", y*32 + 24, 8'(8'h50 + y - 1));
   endtask

   task automatic t_reject;
      int cyc;
      logic [31:0] d;
      wr(A_DB, 2); wr(A_DXY, 32'h0001_0002); wr(A_SIZE, 32'h0);
      run(32'h3300_0000 | FILL, cyc);
      chk("R10 bad fill never busy", 32'(cyc), 32'd0);
      mem_chk("R10 bad fill leaves memory", 50, 8'hA5);
      rd(A_STAT, d); chk("R10 reject flag", d, 32'h4);
      wr(A_STAT, 32'h4); rd(A_STAT, d); chk("R11 clear reject", d, 32'h0);
      run(32'h6600_0000, cyc);
      rd(A_STAT, d); chk("R10 bad copy op flagged", d, 32'h4);
      wr(A_STAT, 32'hFFFF_FFFF); rd(A_STAT, d); chk("R11 clear all", d, 32'h0);
   endtask

   task automatic t_busy_cmd;
      int guard;
      logic [31:0] d;
      wr(A_DB, 0); wr(A_DXY, 32'h0014_0000); wr(A_SIZE, 32'h0003_001F); wr(A_FG, 32'h3C);
      wr(A_CMD, 32'hF000_0000 | FILL);
      wr(A_CMD, 32'hFF00_0000 | FILL);
      wr(A_SIZE, 32'h0);
      guard = 0;
      rd(A_STAT, d);
      while (d[0] && guard < 1000) begin guard++; rd(A_STAT, d); end
      chk("R9 busy command flag", d, 32'h2);
      rd(A_SIZE, d); chk("R9 size write ignored while busy", d, 32'h0003_001F);
      mem_chk("R9 first command result start", 640, 8'h3C);
      mem_chk("R9 first command result end", 767, 8'h3C);
      mem_chk("R8 nothing past rectangle", 768, 8'h00);
      wr(A_STAT, 32'h2); rd(A_STAT, d); chk("R11 clear busy flag", d, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fields();
      t_testport();
      t_fill8();
      t_fill16_xor();
      t_fill32();
      t_copy();
      t_overlap_x();
      t_overlap_y();
      t_reject();
      t_busy_cmd();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule